// File: doc/BRIEF.md
# Split Decade Counter with Preset-Nine

This block is a four-bit decade counter made of two sections that each have their own count input: a divide-by-two section producing `q[0]` and a divide-by-five section producing `q[3:1]`. Both count inputs are treated as slow, asynchronous signals. Each passes through a synchronizer and a falling-edge detector that run on the system clock `clk`, so all state lives in one clock domain. A two-bit chain selector decides how the sections interact. They can run unlinked, or they can be linked internally as an 8421 BCD counter, or as a symmetrical divide-by-ten in which `q[0]` is a square wave.

Two gated controls act on both sections at once. The clear pair (`clr_a`, `clr_b`) zeroes the counter only when both inputs are high. The preset pair (`nine_a`, `nine_b`) loads 1001 only when both inputs are high. Preset wins over clear, and both win over counting. The controls are level sensitive, do not wait for a count edge, and are sampled on every system clock.

The divide-by-two section has two states, BIN_LO and BIN_HI. Its transitions are: toggle on a count tick, load BIN_HI on preset, and load BIN_LO on clear. The divide-by-five section has five states, QN_0 to QN_4, which drive `q[3:1]` as 000, 001, 010, 011 and 100. Its transitions are: step QN_0→QN_1→QN_2→QN_3→QN_4 on each tick, wrap QN_4→QN_0 on a tick, load QN_4 on preset, and load QN_0 on clear. When the section wraps it raises a carry pulse.

Top module: `split_decade_counter`

## Requirements
- R1: While `rst_n` is low, and at the first negative clock phase after `rst_n` rises, `q` is 4'b0000.
- R2: With `chain` = 2'b00, each falling edge of `cnt_a` inverts `q[0]`, and falling edges of `cnt_b` leave `q[0]` unchanged.
- R3: With `chain` = 2'b00, each falling edge of `cnt_b` moves `q[3:1]` through 000, 001, 010, 011, 100 and back to 000. `q[3]` is high only in the 100 state.
- R4: With `chain` = 2'b01, falling edges of `cnt_a` step `q` through 0,1,…,9 and back to 0, including a step from a preset 9 to 0. Falling edges of `cnt_b` have no effect.
- R5: With `chain` = 2'b10, falling edges of `cnt_b` step `q[3:1]` as in R3, and `q[0]` inverts exactly when `q[3:1]` wraps from 100 to 000, so `q[0]` stays high for five input edges and low for five. Falling edges of `cnt_a` have no effect.
- R6: `chain` = 2'b11 behaves exactly as 2'b00.
- R7: When `clr_a` and `clr_b` are both high and the preset pair is not, `q` is 4'b0000 from the next clock edge. One clear input alone has no effect.
- R8: When `nine_a` and `nine_b` are both high, `q` is 4'b1001 from the next clock edge. One preset input alone has no effect.
- R9: Preset takes priority over clear and over count edges. While both preset inputs are high, `q` stays 1001 whatever happens on the clear pair and on `cnt_a` and `cnt_b`.
- R10: A falling count edge changes `q` on the third rising `clk` edge after the input falls. Rising count edges have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every input |
| rst_n | input | 1 | Active-low synchronous system reset |
| cnt_a | input | 1 | Count input of the divide-by-two section |
| cnt_b | input | 1 | Count input of the divide-by-five section |
| chain | input | 2 | Section linkage: 00 unlinked, 01 BCD, 10 symmetrical ÷10, 11 unlinked |
| clr_a | input | 1 | First clear gate input |
| clr_b | input | 1 | Second clear gate input |
| nine_a | input | 1 | First preset-nine gate input |
| nine_b | input | 1 | Second preset-nine gate input |
| q | output | 4 | Counter value; q[0] from the ÷2 section, q[3:1] from the ÷5 section |

## Verification
Each section's state is the output itself, so a wrong internal transition shows on `q` at the next clock edge. It then stays wrong until a clear or a preset. A linkage fault, such as a carry taken from the wrong state or taken in the wrong cycle, only becomes visible when the driving section wraps. For that reason the BCD and symmetrical runs each go through more than a full ten-count cycle. A fault in the edge detector shows as a result that arrives one cycle early or late, or as a double count, so one run checks the exact cycle in which `q` changes.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    typedef enum logic [1:0] {
        CHAIN_NONE = 2'b00,
        CHAIN_BCD  = 2'b01,
        CHAIN_BIQ  = 2'b10,
        CHAIN_ALT  = 2'b11
    } chain_e;

    typedef enum logic [2:0] {
        QN_0 = 3'b000,
        QN_1 = 3'b001,
        QN_2 = 3'b010,
        QN_3 = 3'b011,
        QN_4 = 3'b100
    } quin_e;

    typedef enum logic {
        BIN_LO = 1'b0,
        BIN_HI = 1'b1
    } bin_e;

    localparam logic [3:0] PRESET_VALUE = 4'b1001;

endpackage

// File: rtl/sdc_fall_detect.sv
module sdc_fall_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);
    logic [STAGES-1:0] sync_r;
    logic              last_r;
    logic              synced;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) sync_r <= '0;
                else        sync_r <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) sync_r <= '0;
                else        sync_r <= {sync_r[STAGES-2:0], din};
            end
        end
    endgenerate

    assign synced = sync_r[STAGES-1];

    always_ff @(posedge clk) begin
        if (!rst_n) last_r <= 1'b0;
        else        last_r <= synced;
    end

    assign fall = last_r & ~synced;

    // a falling edge is reported for exactly one cycle
    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/sdc_div2.sv
module sdc_div2
    import sdc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic do_clear,
    input  logic do_preset,
    output logic q0
);
    bin_e state_r, state_nx;

    always_comb begin
        state_nx = state_r;
        if (do_preset)     state_nx = BIN_HI;
        else if (do_clear) state_nx = BIN_LO;
        else if (tick) begin
            unique case (state_r)
                BIN_LO:  state_nx = BIN_HI;
                BIN_HI:  state_nx = BIN_LO;
                default: state_nx = BIN_LO;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_r <= BIN_LO;
        else        state_r <= state_nx;
    end

    always_comb begin
        q0 = (state_r == BIN_HI);
    end

    assert_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !do_clear && !do_preset) |=> (q0 != $past(q0)));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !do_clear && !do_preset) |=> $stable(q0));

endmodule

// File: rtl/sdc_div5.sv
module sdc_div5
    import sdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       do_clear,
    input  logic       do_preset,
    output logic [2:0] q_hi,
    output logic       carry
);
    quin_e state_r, state_nx;

    always_comb begin
        state_nx = state_r;
        if (do_preset)     state_nx = QN_4;
        else if (do_clear) state_nx = QN_0;
        else if (tick) begin
            unique case (state_r)
                QN_0:    state_nx = QN_1;
                QN_1:    state_nx = QN_2;
                QN_2:    state_nx = QN_3;
                QN_3:    state_nx = QN_4;
                QN_4:    state_nx = QN_0;
                default: state_nx = QN_0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_r <= QN_0;
        else        state_r <= state_nx;
    end

    always_comb begin
        q_hi  = state_r;
        carry = tick && (state_r == QN_4);
    end

    assert_q3_alone_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q_hi[2] |-> (q_hi[1:0] == 2'b00));

    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (carry && !do_clear && !do_preset) |=> (q_hi == 3'b000));

endmodule

// File: rtl/split_decade_counter.sv
module split_decade_counter
    import sdc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cnt_a,
    input  logic       cnt_b,
    input  logic [1:0] chain,
    input  logic       clr_a,
    input  logic       clr_b,
    input  logic       nine_a,
    input  logic       nine_b,
    output logic [3:0] q
);
    localparam int N_INPUTS = 2;

    logic [N_INPUTS-1:0] raw_in;
    logic [N_INPUTS-1:0] fall_v;
    logic                a_fall, b_fall;
    logic                do_clear, do_preset;
    logic                tick_a, tick_b;
    logic                q0;
    logic [2:0]          q_hi;
    logic                carry;
    chain_e              link;

    assign raw_in = {cnt_b, cnt_a};

    generate
        for (genvar gi = 0; gi < N_INPUTS; gi++) begin : g_edge
            sdc_fall_detect #(.STAGES(SYNC_STAGES)) u_edge (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (raw_in[gi]),
                .fall (fall_v[gi])
            );
        end
    endgenerate

    assign a_fall    = fall_v[0];
    assign b_fall    = fall_v[1];
    assign do_preset = nine_a & nine_b;
    assign do_clear  = clr_a & clr_b;
    assign link      = chain_e'(chain);

    // linkage: a chained edge is applied in the same cycle as its cause
    always_comb begin
        tick_a = a_fall;
        tick_b = b_fall;
        unique case (link)
            CHAIN_BCD: begin
                tick_a = a_fall;
                tick_b = a_fall & q0;
            end
            CHAIN_BIQ: begin
                tick_b = b_fall;
                tick_a = carry;
            end
            CHAIN_NONE, CHAIN_ALT: begin
                tick_a = a_fall;
                tick_b = b_fall;
            end
            default: begin
                tick_a = a_fall;
                tick_b = b_fall;
            end
        endcase
    end

    sdc_div2 u_bin (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_a),
        .do_clear (do_clear),
        .do_preset(do_preset),
        .q0       (q0)
    );

    sdc_div5 u_quin (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_b),
        .do_clear (do_clear),
        .do_preset(do_preset),
        .q_hi     (q_hi),
        .carry    (carry)
    );

    always_comb begin
        q = {q_hi, q0};
    end

    assert_preset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (nine_a && nine_b) |=> (q == PRESET_VALUE));

    assert_preset_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (nine_a && nine_b && clr_a && clr_b) |=> (q == PRESET_VALUE));

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_a && clr_b && !(nine_a && nine_b)) |=> (q == 4'b0000));

    assert_bcd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (chain == 2'b01 && !a_fall && !do_clear && !do_preset) |=> $stable(q));

    assert_biq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (chain == 2'b10 && !b_fall && !do_clear && !do_preset) |=> $stable(q));

endmodule

// File: tb/sim_split_decade_counter.sv
module sim_split_decade_counter;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cnt_a, cnt_b;
    logic [1:0] chain;
    logic       clr_a, clr_b, nine_a, nine_b;
    logic [3:0] q;

    int  n_run = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    logic [3:0] exp_q[$];
    string      tag_q[$];
    logic [3:0] pop_val;
    string      pop_tag;

    logic       m_q0;
    logic [2:0] m_d5;

    always #(CLK_PERIOD/2) clk = ~clk;

    split_decade_counter u0 (
        .clk(clk), .rst_n(rst_n), .cnt_a(cnt_a), .cnt_b(cnt_b), .chain(chain),
        .clr_a(clr_a), .clr_b(clr_b), .nine_a(nine_a), .nine_b(nine_b), .q(q)
    );

    task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: q=%b expected %b", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] model_q();
        return {m_d5, m_q0};
    endfunction

    function automatic logic [2:0] step5(input logic [2:0] v);
        return (v == 3'd4) ? 3'd0 : v + 3'd1;
    endfunction

    task automatic push(input string tag);
        exp_q.push_back(model_q());
        tag_q.push_back(tag);
    endtask

    // monitor: compares queued expectations against the output
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                pop_val = exp_q.pop_front();
                pop_tag = tag_q.pop_front();
                check(q, pop_val, pop_tag);
            end
        end
    end

    task automatic model_a_fall();
        case (chain)
            2'b10: ;
            2'b01: begin
                if (m_q0) begin m_q0 = 1'b0; m_d5 = step5(m_d5); end
                else m_q0 = 1'b1;
            end
            default: m_q0 = ~m_q0;
        endcase
    endtask

    task automatic model_b_fall();
        case (chain)
            2'b01: ;
            2'b10: begin
                if (m_d5 == 3'd4) m_q0 = ~m_q0;
                m_d5 = step5(m_d5);
            end
            default: m_d5 = step5(m_d5);
        endcase
    endtask

    task automatic pulse(input bit on_b);
        @(negedge clk);
        if (on_b) cnt_b = 1'b1; else cnt_a = 1'b1;
        repeat (5) @(negedge clk);
        if (on_b) cnt_b = 1'b0; else cnt_a = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic count(input bit on_b, input string tag);
        pulse(on_b);
        if (!(nine_a && nine_b)) begin
            if (on_b) model_b_fall(); else model_a_fall();
        end
        push(tag);
    endtask

    task automatic drive_ctrl(input logic c1, input logic c2, input logic s1, input logic s2,
                              input string tag);
        @(negedge clk);
        clr_a = c1; clr_b = c2; nine_a = s1; nine_b = s2;
        if (s1 && s2) begin m_q0 = 1'b1; m_d5 = 3'd4; end
        else if (c1 && c2) begin m_q0 = 1'b0; m_d5 = 3'd0; end
        repeat (2) @(negedge clk);
        push(tag);
        repeat (2) @(negedge clk);
    endtask

    task automatic release_ctrl();
        @(negedge clk);
        clr_a = 1'b0; clr_b = 1'b0; nine_a = 1'b0; nine_b = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; cnt_a = 1'b0; cnt_b = 1'b0; chain = 2'b00;
        clr_a = 1'b0; clr_b = 1'b0; nine_a = 1'b0; nine_b = 1'b0;
        m_q0 = 1'b0; m_d5 = 3'd0;
        repeat (3) @(negedge clk);
        check(q, 4'b0000, "R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        push("R1 after reset");

        // unlinked sections
        for (int i = 0; i < 3; i++) count(1'b0, "R2 cnt_a toggles q0");
        for (int i = 0; i < 6; i++) count(1'b1, "R3 cnt_b quinary step");
        chain = 2'b11;
        for (int i = 0; i < 2; i++) count(1'b0, "R6 code 11 cnt_a");
        count(1'b1, "R6 code 11 cnt_b");

        // gated clear
        drive_ctrl(1'b1, 1'b0, 1'b0, 1'b0, "R7 single clear input ignored");
        release_ctrl();
        drive_ctrl(1'b1, 1'b1, 1'b0, 1'b0, "R7 clear pair");
        release_ctrl();
        push("R7 stays clear after release");

        // BCD linkage
        chain = 2'b01;
        for (int i = 0; i < 12; i++) count(1'b0, "R4 bcd step");
        for (int i = 0; i < 2; i++) count(1'b1, "R4 cnt_b ignored in bcd");

        // preset
        drive_ctrl(1'b0, 1'b0, 1'b0, 1'b1, "R8 single preset input ignored");
        release_ctrl();
        drive_ctrl(1'b0, 1'b0, 1'b1, 1'b1, "R8 preset pair");
        release_ctrl();
        count(1'b0, "R4 wrap from preset nine");

        // preset priority
        drive_ctrl(1'b1, 1'b1, 1'b1, 1'b1, "R9 preset over clear");
        count(1'b0, "R9 cnt_a during preset");
        count(1'b1, "R9 cnt_b during preset");
        release_ctrl();

        // symmetrical divide-by-ten
        drive_ctrl(1'b1, 1'b1, 1'b0, 1'b0, "R7 clear before biq");
        release_ctrl();
        chain = 2'b10;
        for (int i = 0; i < 12; i++) count(1'b1, "R5 biq step");
        count(1'b0, "R5 cnt_a ignored in biq");

        // edge latency in unlinked mode
        chain = 2'b00;
        @(negedge clk);
        cnt_a = 1'b1;
        repeat (5) @(negedge clk);
        check(q, model_q(), "R10 rising edge no effect");
        cnt_a = 1'b0;
        @(negedge clk);
        check(q, model_q(), "R10 unchanged after 1st edge");
        @(negedge clk);
        check(q, model_q(), "R10 unchanged after 2nd edge");
        @(negedge clk);
        model_a_fall();
        check(q, model_q(), "R10 changed after 3rd edge");

        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule